// File: doc/BRIEF.md
# Three-Leg Gate Command Conditioner

This block sits between a motor-control PWM source and the gate drivers of a three-phase inverter bridge. For each of the three legs it takes one high-side and one low-side command. Both commands are active low. It returns one active-high enable per switch. Each command first goes through a two-flop synchronizer. It then goes through a digital filter that rejects short pulses, and the filter window depends on the side and on the edge direction. Each leg then gets a stage that never lets both switches of that leg conduct at once. The same stage adds a fixed dead time before the opposite switch of a leg may turn on.

A global force-off input turns all six enables off, whatever the commands say. One clock drives every timing count. All durations are parameters in clock cycles. The defaults are 27 cycles for the low-side filter in both directions and for the high-side turn-on filter, 22 cycles for the high-side turn-off filter, and 38 cycles of dead time. Every enable stays off while reset is active. It also stays off for a settle window after reset, until the filters hold valid levels.

The block has no data stream: every pin is a plain control level with no handshake.

Top module: `hb_gate_front`

## Requirements
- R1: A low level on `hs_cmd_n[i]` or `ls_cmd_n[i]` requests that switch of leg i on, and a high level requests it off. The enables `hs_gate[i]` and `ls_gate[i]` are active high, and bit i belongs to leg i.
- R2: While `rst_n` is low every enable is 0, and the synchronizers read every command as off. After reset is released, no enable rises during the first SETTLE_CYC clock edges. SETTLE_CYC is the longest filter window plus SYNC_STAGES plus 1, which is 30 by default.
- R3: A low-side command change takes effect only after it has held its new level for LS_FILT_CYC (27) consecutive cycles, and this applies to both directions. Shorter pulses are ignored. With no dead-time wait, an enable follows a command change after SYNC_STAGES + LS_FILT_CYC + 1 = 30 clock edges.
- R4: A high-side turn-on request is ignored unless it holds for HS_ON_CYC (27) cycles.
- R5: A high-side turn-off request is ignored unless it holds for HS_OFF_CYC (22) cycles. The enable falls 25 clock edges after the command rises.
- R6: `hs_gate[i]` and `ls_gate[i]` are never 1 together. When both commands of a leg request on, both enables of that leg are 0.
- R7: After one switch of a leg turns off, the opposite switch stays off for at least DEAD_CYC (38) cycles. If the opposite command is already waiting, both enables of that leg are 0 for exactly DEAD_CYC cycles.
- R8: Turning the same switch back on, with no opposite switch on in between, involves no dead-time wait.
- R9: All six enables are 0 from the third clock edge after `force_off` rises, and they stay 0 while it is high, whatever the commands are. Enables that are still requested come back three edges after `force_off` falls.
- R10: Each leg acts independently of the other two legs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_cmd_n | input | NUM_LEGS | High-side commands, active low, bit i = leg i |
| ls_cmd_n | input | NUM_LEGS | Low-side commands, active low, bit i = leg i |
| force_off | input | 1 | Active-high global shutdown |
| hs_gate | output | NUM_LEGS | High-side gate enables, active high |
| ls_gate | output | NUM_LEGS | Low-side gate enables, active high |

## Verification
Four properties hold on every cycle, and the bound checker tests all four:
- the two switches of a leg are never on together;
- no enable is on during the post-reset settle window;
- every enable is off once `force_off` has been seen for long enough to pass the synchronizer;
- a switch never turns on after its opposite switch until both have been off for the dead time.

Other behaviours depend on input history, so only the bench scenarios can show them:
- how wide a pulse the filters let through, for each side and direction;
- the exact edge count from a command change to its enable;
- that a switch turning back on after itself skips the dead time;
- that the enables recover after `force_off` is released.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef struct packed {
    logic hs;
    logic ls;
  } leg_pair_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/hb_glitch_filt.sv
module hb_glitch_filt
  import hb_gate_pkg::*;
#(
  parameter int ON_CYC  = 27,
  parameter int OFF_CYC = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic req_o
);

  localparam int CW = $clog2(max_of(ON_CYC, OFF_CYC) + 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] need;
  logic          lvl_q;

  // the window depends on the direction of the pending change
  assign need = lvl_q ? CW'(OFF_CYC - 1) : CW'(ON_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (req_i == lvl_q) begin
      run_q <= '0;
    end else if (run_q >= need) begin
      lvl_q <= req_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign req_o = lvl_q;

endmodule

// File: rtl/hb_leg_ctrl.sv
module hb_leg_ctrl
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC = 38
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      kill_i,
  input  leg_pair_t req_i,
  output leg_pair_t gate_o
);

  localparam int GW = $clog2(DEAD_CYC + 1);

  leg_pair_t     gate_q;
  logic [GW-1:0] gap_q;
  logic          last_lo_q;
  logic          gap_ok, solo_hs, solo_ls, hs_d, ls_d;

  assign gap_ok  = (gap_q >= GW'(DEAD_CYC - 1));
  assign solo_hs = req_i.hs & ~req_i.ls & ~kill_i;
  assign solo_ls = req_i.ls & ~req_i.hs & ~kill_i;
  // the dead-time gap applies only when the other side conducted last
  assign hs_d = solo_hs & ~gate_q.ls & (gate_q.hs | ~last_lo_q | gap_ok);
  assign ls_d = solo_ls & ~gate_q.hs & (gate_q.ls |  last_lo_q | gap_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q    <= '0;
      gap_q     <= GW'(DEAD_CYC);
      last_lo_q <= 1'b0;
    end else begin
      gate_q.hs <= hs_d;
      gate_q.ls <= ls_d;
      if (gate_q.hs | gate_q.ls)      gap_q <= '0;
      else if (gap_q != GW'(DEAD_CYC)) gap_q <= gap_q + 1'b1;
      if (gate_q.ls)      last_lo_q <= 1'b1;
      else if (gate_q.hs) last_lo_q <= 1'b0;
    end
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/hb_gate_front.sv
module hb_gate_front
  import hb_gate_pkg::*;
#(
  parameter int NUM_LEGS    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LS_FILT_CYC = 27,
  parameter int HS_ON_CYC   = 27,
  parameter int HS_OFF_CYC  = 22,
  parameter int DEAD_CYC    = 38
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_LEGS-1:0] hs_cmd_n,
  input  logic [NUM_LEGS-1:0] ls_cmd_n,
  input  logic                force_off,
  output logic [NUM_LEGS-1:0] hs_gate,
  output logic [NUM_LEGS-1:0] ls_gate
);

  localparam int MAX_FILT   = max_of(LS_FILT_CYC, max_of(HS_ON_CYC, HS_OFF_CYC));
  localparam int SETTLE_CYC = MAX_FILT + SYNC_STAGES + 1;
  localparam int SW         = $clog2(SETTLE_CYC + 1);
  localparam int IN_W       = 2 * NUM_LEGS + 1;

  logic [IN_W-1:0]     raw_in, sync_out;
  logic [NUM_LEGS-1:0] hs_s, ls_s;
  logic                fo_s, kill;
  logic [SW-1:0]       settle_q;
  logic                ready_q;

  assign raw_in = {force_off, ls_cmd_n, hs_cmd_n};

  hb_sync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({1'b0, {(2 * NUM_LEGS){1'b1}}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_out)
  );

  assign hs_s = sync_out[NUM_LEGS-1:0];
  assign ls_s = sync_out[2*NUM_LEGS-1:NUM_LEGS];
  assign fo_s = sync_out[IN_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      ready_q  <= 1'b0;
    end else if (!ready_q) begin
      settle_q <= settle_q + 1'b1;
      if (settle_q == SW'(SETTLE_CYC - 1)) ready_q <= 1'b1;
    end
  end

  assign kill = fo_s | ~ready_q;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    leg_pair_t req, gate;

    hb_glitch_filt #(
      .ON_CYC (HS_ON_CYC),
      .OFF_CYC(HS_OFF_CYC)
    ) u_hs_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .req_i(~hs_s[g]),
      .req_o(req.hs)
    );

    hb_glitch_filt #(
      .ON_CYC (LS_FILT_CYC),
      .OFF_CYC(LS_FILT_CYC)
    ) u_ls_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .req_i(~ls_s[g]),
      .req_o(req.ls)
    );

    hb_leg_ctrl #(
      .DEAD_CYC(DEAD_CYC)
    ) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .kill_i(kill),
      .req_i (req),
      .gate_o(gate)
    );

    assign hs_gate[g] = gate.hs;
    assign ls_gate[g] = gate.ls;
  end

endmodule

// File: rtl/hb_gate_front_chk.sv
module hb_gate_front_chk
  import hb_gate_pkg::*;
#(
  parameter int NUM_LEGS    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LS_FILT_CYC = 27,
  parameter int HS_ON_CYC   = 27,
  parameter int HS_OFF_CYC  = 22,
  parameter int DEAD_CYC    = 38
) (
  input logic                clk,
  input logic                rst_n,
  input logic                force_off,
  input logic [NUM_LEGS-1:0] hs_gate,
  input logic [NUM_LEGS-1:0] ls_gate
);

  localparam int SETTLE = max_of(LS_FILT_CYC, max_of(HS_ON_CYC, HS_OFF_CYC)) + SYNC_STAGES + 1;
  localparam int CW     = $clog2(SETTLE + 2);
  localparam int FW     = $clog2(SYNC_STAGES + 2);
  localparam int DW     = $clog2(DEAD_CYC + 1);

  logic [CW-1:0] cyc_q;
  logic [FW-1:0] fo_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= '0;
      fo_run_q <= '0;
    end else begin
      if (cyc_q != CW'(SETTLE + 1)) cyc_q <= cyc_q + 1'b1;
      if (!force_off)                       fo_run_q <= '0;
      else if (fo_run_q != FW'(SYNC_STAGES + 1)) fo_run_q <= fo_run_q + 1'b1;
    end
  end

  AST_SETTLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q <= CW'(SETTLE)) |-> (hs_gate == '0 && ls_gate == '0)); // R2

  AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_run_q >= FW'(SYNC_STAGES + 1)) |-> (hs_gate == '0 && ls_gate == '0)); // R9

  AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate & ls_gate) == '0); // R6

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_dead
    logic [DW-1:0] off_run_q;
    logic          saw_hs_q, saw_ls_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_run_q <= DW'(DEAD_CYC);
        saw_hs_q  <= 1'b0;
        saw_ls_q  <= 1'b0;
      end else begin
        if (hs_gate[g] | ls_gate[g])          off_run_q <= '0;
        else if (off_run_q != DW'(DEAD_CYC))  off_run_q <= off_run_q + 1'b1;
        if (hs_gate[g]) begin saw_hs_q <= 1'b1; saw_ls_q <= 1'b0; end
        else if (ls_gate[g]) begin saw_ls_q <= 1'b1; saw_hs_q <= 1'b0; end
      end
    end

    AST_DEAD_HS: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_gate[g] && !$past(hs_gate[g]) && saw_ls_q) |-> (off_run_q >= DW'(DEAD_CYC))); // R7

    AST_DEAD_LS: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_gate[g] && !$past(ls_gate[g]) && saw_hs_q) |-> (off_run_q >= DW'(DEAD_CYC))); // R7
  end

endmodule

bind hb_gate_front hb_gate_front_chk #(
  .NUM_LEGS   (NUM_LEGS),
  .SYNC_STAGES(SYNC_STAGES),
  .LS_FILT_CYC(LS_FILT_CYC),
  .HS_ON_CYC  (HS_ON_CYC),
  .HS_OFF_CYC (HS_OFF_CYC),
  .DEAD_CYC   (DEAD_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .force_off(force_off),
  .hs_gate  (hs_gate),
  .ls_gate  (ls_gate)
);

// File: tb/hb_gate_front_tb.sv
module hb_gate_front_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hs_cmd_n = 3'b111;
  logic [2:0] ls_cmd_n = 3'b110;
  logic       force_off = 1'b0;
  logic [2:0] hs_gate, ls_gate;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  hb_gate_front u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_cmd_n (hs_cmd_n),
    .ls_cmd_n (ls_cmd_n),
    .force_off(force_off),
    .hs_gate  (hs_gate),
    .ls_gate  (ls_gate)
  );

  // {hs_cmd_n, ls_cmd_n, force_off, expected hs_gate, expected ls_gate}
  localparam logic [12:0] VEC [10] = '{
    {3'b111, 3'b111, 1'b0, 3'b000, 3'b000},
    {3'b110, 3'b111, 1'b0, 3'b001, 3'b000},
    {3'b111, 3'b110, 1'b0, 3'b000, 3'b001},
    {3'b010, 3'b101, 1'b0, 3'b101, 3'b010},
    {3'b000, 3'b000, 1'b0, 3'b000, 3'b000},
    {3'b110, 3'b110, 1'b0, 3'b000, 3'b000},
    {3'b101, 3'b010, 1'b0, 3'b010, 3'b101},
    {3'b101, 3'b010, 1'b1, 3'b000, 3'b000},
    {3'b101, 3'b010, 1'b0, 3'b010, 3'b101},
    {3'b111, 3'b111, 1'b0, 3'b000, 3'b000}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // drive one command bit to lvl for w cycles, restore, count enable-on samples
  task automatic pulse(input bit hs_side, input int leg, input logic lvl,
                       input int w, output int on_cnt);
    on_cnt = 0;
    if (hs_side) hs_cmd_n[leg] = lvl; else ls_cmd_n[leg] = lvl;
    for (int k = 0; k < w + 80; k++) begin
      if (k == w) begin
        if (hs_side) hs_cmd_n[leg] = ~lvl; else ls_cmd_n[leg] = ~lvl;
      end
      step(1);
      if (hs_side ? hs_gate[leg] : ls_gate[leg]) on_cnt++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin : main
    int cnt;
    bit fell;
    // reset with leg0 low side already requested
    step(5);
    chk("R2 outputs off in reset", {hs_gate, ls_gate}, 0);
    rst_n = 1'b1;
    step(20);
    chk("R2 settle window keeps enables off", {hs_gate, ls_gate}, 0);
    step(20);
    chk("R1 low command turns low side on", ls_gate, 3'b001);
    ls_cmd_n = 3'b111;
    step(100);

    // table of steady-state vectors
    for (int k = 0; k < 10; k++) begin
      hs_cmd_n  = VEC[k][12:10];
      ls_cmd_n  = VEC[k][9:7];
      force_off = VEC[k][6];
      step(100);
      chk($sformatf("R1 R6 R9 R10 vector %0d", k), {hs_gate, ls_gate}, VEC[k][5:0]);
    end

    // R3 exact latency, on and off
    ls_cmd_n[0] = 1'b0;
    step(29);
    chk("R3 ls on not before 30 edges", ls_gate[0], 0);
    step(1);
    chk("R3 ls on at 30 edges", ls_gate[0], 1);
    ls_cmd_n[0] = 1'b1;
    step(29);
    chk("R3 ls off not before 30 edges", ls_gate[0], 1);
    step(1);
    chk("R3 ls off at 30 edges", ls_gate[0], 0);
    // R8 same switch back on with no dead-time wait
    ls_cmd_n[0] = 1'b0;
    step(30);
    chk("R8 same side re-on without dead time", ls_gate[0], 1);

    // R3 low-side pulse rejection
    pulse(1'b0, 0, 1'b1, 26, cnt);
    chk("R3 26-cycle ls off pulse ignored", cnt, 106);
    pulse(1'b0, 0, 1'b1, 27, cnt);
    chk("R3 27-cycle ls off pulse passes", (cnt < 107) ? 1 : 0, 1);
    ls_cmd_n[0] = 1'b1;
    step(60);
    pulse(1'b0, 0, 1'b0, 26, cnt);
    chk("R3 26-cycle ls on pulse ignored", cnt, 0);

    // R4 / R5 high-side asymmetric filters on leg1
    hs_cmd_n[1] = 1'b0;
    step(60);
    chk("R4 hs leg1 on", hs_gate[1], 1);
    pulse(1'b1, 1, 1'b1, 21, cnt);
    chk("R5 21-cycle hs off pulse ignored", cnt, 101);
    pulse(1'b1, 1, 1'b1, 22, cnt);
    chk("R5 22-cycle hs off pulse passes", (cnt < 102) ? 1 : 0, 1);
    step(60);
    hs_cmd_n[1] = 1'b1;
    step(24);
    chk("R5 hs off not before 25 edges", hs_gate[1], 1);
    step(1);
    chk("R5 hs off at 25 edges", hs_gate[1], 0);
    step(60);
    pulse(1'b1, 1, 1'b0, 26, cnt);
    chk("R4 26-cycle hs on pulse ignored", cnt, 0);
    pulse(1'b1, 1, 1'b0, 27, cnt);
    chk("R4 27-cycle hs on pulse passes", (cnt > 0) ? 1 : 0, 1);
    step(60);

    // R7 exact dead time on leg2, hs -> ls
    hs_cmd_n[2] = 1'b0;
    step(100);
    chk("R7 leg2 hs on before swap", hs_gate[2], 1);
    hs_cmd_n[2] = 1'b1;
    ls_cmd_n[2] = 1'b0;
    cnt  = 0;
    fell = 0;
    for (int k = 0; k < 150; k++) begin
      step(1);
      if (!hs_gate[2]) fell = 1;
      if (fell && !hs_gate[2] && !ls_gate[2]) cnt++;
      if (ls_gate[2]) break;
    end
    chk("R7 both off for exactly dead time", cnt, 38);
    chk("R6 R10 only leg2 low side on", {hs_gate, ls_gate}, 6'b000_100);

    // R9 force_off latency, hold and release
    force_off = 1'b1;
    step(2);
    chk("R9 still on after 2 edges", ls_gate[2], 1);
    step(1);
    chk("R9 off at 3 edges", ls_gate[2], 0);
    hs_cmd_n = 3'b000;
    step(50);
    chk("R9 commands ignored while forced", {hs_gate, ls_gate}, 0);
    hs_cmd_n = 3'b111;
    step(60);
    chk("R9 still off while forced", {hs_gate, ls_gate}, 0);
    force_off = 1'b0;
    step(2);
    chk("R9 off 2 edges after release", ls_gate[2], 0);
    step(1);
    chk("R9 resumes 3 edges after release", ls_gate[2], 1);

    report();
  end

endmodule